// File: doc/BRIEF.md
# PWM Timer with Emergency Output Shutdown

This block is an 8-bit timer channel. It counts pulses from one of twelve enable sources. It compares the count against a compare value that software writes through a small register port. The new compare value waits in a holding register until the current period ends. The channel works in one of four modes:

- toggle (square-wave) output;
- 256-step PWM output, with a 2-bit fraction that adds one extra high tick to some periods in each group of four;
- counting of edges on an external pin;
- measuring how long an external pin stays high.

A falling edge on the active-low interrupt line can latch the output pin into a programmed safe condition: driven low, driven high, or released (output-enable low). The safe condition holds until software releases it. The counter keeps running underneath. The interrupt line and the event pin are asynchronous, so each passes through a two-stage synchronizer before any edge is detected. Everything runs on one clock. The slower count rates reach the block as single-cycle enables, not as clocks.

Top module: `pwm_guard_timer`

## Requirements
- R1: After reset, `tmr_out` is 0, `tmr_oe` is 1, `cap_val` is 0 and `cap_done` is 0.
- R2: A write to address 0 sets the control fields: bits 1:0 = mode (0 toggle, 1 PWM, 2 event count, 3 width measure), bits 3:2 = safe state, bit 4 = arm, bit 5 = run, bit 6 = release strobe. While run is 0, the counter sits at zero and `tmr_out` goes low within two cycles. Values written to address 2 (compare) and to address 3 bits 1:0 (fraction) also go straight into the active copies while run is 0.
- R3: In mode 0 with compare C, `tmr_out` inverts once every C+1 count ticks. Valid range is C = 0..255.
- R4: Address 1 bits 3:0 choose the tick source. Code 0 ticks every cycle. Codes 1..9 follow `div_en[code-1]`. Code 10 ticks on a synchronized rising edge of `ext_in`. Code 11 follows `partner_tick`. Codes 12..15 never tick.
- R5: A compare written while the channel runs does not affect the half-period in progress. It applies from the next counter clear onward.
- R6: In mode 1 with compare C and fraction F, each period lasts 256 ticks. Period k of each group of four (k = 0..3) is high for C+1 ticks when F is greater than the bit-reversed value of k. Otherwise it is high for C ticks. Any 1024 consecutive cycles at one tick per cycle therefore hold 4C+F high cycles.
- R7: In mode 2, the count advances on each synchronized rising edge of `ext_in`, whatever the source code. `tmr_out` inverts on every (C+1)-th edge.
- R8: In mode 3, a rising edge of `ext_in` clears `cap_done`, and the count then advances on each tick while `ext_in` stays high. The count saturates at 255. The falling edge loads the count into `cap_val` and sets `cap_done`. With one tick per cycle, `cap_val` equals the high time in cycles.
- R9: When arm (bit 4) is 1, a falling edge on `irq_n` forces the pin into the safe state. Safe code 0 gives out 0 / oe 1, code 1 gives out 1 / oe 1, and codes 2 and 3 give oe 0. When arm is 0, the edge has no effect.
- R10: The forced state persists while `irq_n` returns high. It ends only when a control write carries the release bit. Normal output then resumes with its timing unchanged.
- R11: `tmr_oe` and `tmr_out` reach the forced state on the fourth rising clock edge after `irq_n` falls, and not on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| div_en | input | 9 | Prescaled tick enables for source codes 1..9 |
| partner_tick | input | 1 | Tick from another timer (source code 11) |
| ext_in | input | 1 | Asynchronous event / width / clock input |
| irq_n | input | 1 | Asynchronous active-low emergency interrupt |
| tmr_out | output | 1 | Timer output level |
| tmr_oe | output | 1 | Timer output enable |
| cap_val | output | 8 | Captured pulse width |
| cap_done | output | 1 | Capture-complete flag |

## Verification
Counter or compare corruption in toggle and event modes shows up as a wrong interval between output transitions. This is visible within one half-period. A wrong active compare or fraction in PWM mode changes the high count of a 1024-cycle window by at least one. A stuck or mis-armed forcing latch shows up as `tmr_oe` or `tmr_out` differing from the programmed safe code on the fourth edge after the interrupt falls. It also shows up as the safe state failing to clear when software releases it. A miscounting width counter appears in `cap_val` a few cycles after the input falls.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'd0,
    MODE_PWM    = 2'd1,
    MODE_EVENT  = 2'd2,
    MODE_WIDTH  = 2'd3
  } pgt_mode_e;

  typedef enum logic [1:0] {
    SAFE_LOW   = 2'd0,
    SAFE_HIGH  = 2'd1,
    SAFE_FLOAT = 2'd2,
    SAFE_FLT2  = 2'd3
  } pgt_safe_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CSEL = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;
  localparam logic [1:0] ADDR_FRAC = 2'd3;

  localparam int unsigned CTL_ARM_BIT = 4;
  localparam int unsigned CTL_RUN_BIT = 5;
  localparam int unsigned CTL_REL_BIT = 6;

endpackage

// File: rtl/pgt_sync.sv
module pgt_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);

  logic [W-1:0] meta_q;
  logic [W-1:0] lvl_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= IDLE;
      lvl_q  <= IDLE;
      prev_q <= IDLE;
    end else begin
      meta_q <= async_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl   = lvl_q;
  assign lvl_d = prev_q;

endmodule

// File: rtl/pgt_tick_sel.sv
module pgt_tick_sel #(
  parameter int unsigned NDIV = 9,
  parameter int unsigned SELW = 4
) (
  input  logic [NDIV-1:0] div_en,
  input  logic            ext_rise,
  input  logic            partner_tick,
  input  logic [SELW-1:0] sel,
  output logic            tick
);

  localparam int unsigned NSRC = NDIV + 3;
  localparam int unsigned NPAD = 1 << SELW;

  logic [NPAD-1:0] src;

  assign src[0] = 1'b1;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    assign src[i+1] = div_en[i];
  end

  assign src[NDIV+1] = ext_rise;
  assign src[NDIV+2] = partner_tick;

  for (genvar j = NSRC; j < NPAD; j++) begin : g_pad
    assign src[j] = 1'b0;
  end

  assign tick = src[sel];

endmodule

// File: rtl/pgt_core.sv
module pgt_core
  import pgt_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned FW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  pgt_mode_e     mode,
  input  logic          tick,
  input  logic          ext_lvl,
  input  logic          ext_rise,
  input  logic          ext_fall,
  input  logic [CW-1:0] cmp_buf,
  input  logic [FW-1:0] frac_buf,
  output logic          wave,
  output logic [CW-1:0] cap_val,
  output logic          cap_done,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp_act
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cmp_q;
  logic [FW-1:0] frac_q;
  logic [FW-1:0] grp_q;
  logic          sq_q;
  logic          wave_q;
  logic [CW-1:0] cap_q;
  logic          done_q;

  logic          step;
  logic [FW-1:0] grp_rev;
  logic          add_pulse;
  logic          pwm_lvl;
  logic          at_cmp;

  // bit-reversed period index spreads the extra ticks evenly over the group
  for (genvar b = 0; b < FW; b++) begin : g_rev
    assign grp_rev[b] = grp_q[FW-1-b];
  end

  always_comb begin
    step      = (mode == MODE_EVENT) ? ext_rise : tick;
    at_cmp    = (cnt_q == cmp_q);
    add_pulse = (frac_q > grp_rev);
    pwm_lvl   = (cnt_q < cmp_q) || (add_pulse && at_cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      frac_q <= '0;
      grp_q  <= '0;
      sq_q   <= 1'b0;
      wave_q <= 1'b0;
      cap_q  <= '0;
      done_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      grp_q  <= '0;
      cmp_q  <= cmp_buf;
      frac_q <= frac_buf;
      sq_q   <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      case (mode)
        MODE_TOGGLE, MODE_EVENT: begin
          wave_q <= sq_q;
          if (step) begin
            if (at_cmp) begin
              cnt_q <= '0;
              sq_q  <= ~sq_q;
              cmp_q <= cmp_buf;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        MODE_PWM: begin
          wave_q <= pwm_lvl;
          if (step) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CMAX) begin
              cmp_q  <= cmp_buf;
              frac_q <= frac_buf;
              grp_q  <= grp_q + 1'b1;
            end
          end
        end
        default: begin
          wave_q <= 1'b0;
          if (ext_rise) begin
            cnt_q  <= {{(CW-1){1'b0}}, step};
            done_q <= 1'b0;
          end else if (ext_lvl) begin
            if (step && (cnt_q != CMAX)) cnt_q <= cnt_q + 1'b1;
          end
          if (ext_fall) begin
            cap_q  <= cnt_q;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign wave     = wave_q;
  assign cap_val  = cap_q;
  assign cap_done = done_q;
  assign cnt      = cnt_q;
  assign cmp_act  = cmp_q;

endmodule

// File: rtl/pgt_guard.sv
module pgt_guard
  import pgt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      arm,
  input  pgt_safe_e safe_sel,
  input  logic      release_req,
  input  logic      irq_fall,
  input  logic      wave,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      forced
);

  logic forced_q;
  logic out_q;
  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      forced_q <= 1'b0;
      out_q    <= 1'b0;
      oe_q     <= 1'b1;
    end else begin
      // a new emergency edge wins over a release in the same cycle
      if (arm && irq_fall)  forced_q <= 1'b1;
      else if (release_req) forced_q <= 1'b0;

      if (forced_q) begin
        case (safe_sel)
          SAFE_LOW:  begin out_q <= 1'b0; oe_q <= 1'b1; end
          SAFE_HIGH: begin out_q <= 1'b1; oe_q <= 1'b1; end
          default:   begin out_q <= 1'b0; oe_q <= 1'b0; end
        endcase
      end else begin
        out_q <= wave;
        oe_q  <= 1'b1;
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign forced  = forced_q;

endmodule

// File: rtl/pwm_guard_timer.sv
module pwm_guard_timer
  import pgt_pkg::*;
#(
  parameter int unsigned CW   = 8,
  parameter int unsigned FW   = 2,
  parameter int unsigned NDIV = 9,
  parameter int unsigned SELW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [NDIV-1:0] div_en,
  input  logic            partner_tick,
  input  logic            ext_in,
  input  logic            irq_n,
  output logic            tmr_out,
  output logic            tmr_oe,
  output logic [CW-1:0]   cap_val,
  output logic            cap_done
);

  pgt_mode_e       mode_q;
  pgt_safe_e       safe_q;
  logic            arm_q;
  logic            run_q;
  logic [SELW-1:0] csel_q;
  logic [CW-1:0]   cmp_buf_q;
  logic [FW-1:0]   frac_buf_q;

  logic            ctrl_wr;
  logic            release_req;

  logic [1:0]      s_lvl;
  logic [1:0]      s_prev;
  logic            ext_rise;
  logic            ext_fall;
  logic            irq_fall;
  logic            tick;
  logic            wave;
  logic            forced;
  logic [CW-1:0]   core_cnt;
  logic [CW-1:0]   core_cmp;

  assign ctrl_wr     = wr_en && (wr_addr == ADDR_CTRL);
  assign release_req = ctrl_wr && wr_data[CTL_REL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_TOGGLE;
      safe_q     <= SAFE_LOW;
      arm_q      <= 1'b0;
      run_q      <= 1'b0;
      csel_q     <= '0;
      cmp_buf_q  <= '0;
      frac_buf_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          mode_q <= pgt_mode_e'(wr_data[1:0]);
          safe_q <= pgt_safe_e'(wr_data[3:2]);
          arm_q  <= wr_data[CTL_ARM_BIT];
          run_q  <= wr_data[CTL_RUN_BIT];
        end
        ADDR_CSEL: csel_q     <= wr_data[SELW-1:0];
        ADDR_CMP:  cmp_buf_q  <= wr_data;
        default:   frac_buf_q <= wr_data[FW-1:0];
      endcase
    end
  end

  // bit 1: interrupt (idles high), bit 0: external input
  pgt_sync #(.W(2), .IDLE(2'b10)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({irq_n, ext_in}),
    .lvl      (s_lvl),
    .lvl_d    (s_prev)
  );

  assign ext_rise =  s_lvl[0] & ~s_prev[0];
  assign ext_fall = ~s_lvl[0] &  s_prev[0];
  assign irq_fall = ~s_lvl[1] &  s_prev[1];

  pgt_tick_sel #(.NDIV(NDIV), .SELW(SELW)) u_tick (
    .div_en       (div_en),
    .ext_rise     (ext_rise),
    .partner_tick (partner_tick),
    .sel          (csel_q),
    .tick         (tick)
  );

  pgt_core #(.CW(CW), .FW(FW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .mode     (mode_q),
    .tick     (tick),
    .ext_lvl  (s_lvl[0]),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .cmp_buf  (cmp_buf_q),
    .frac_buf (frac_buf_q),
    .wave     (wave),
    .cap_val  (cap_val),
    .cap_done (cap_done),
    .cnt      (core_cnt),
    .cmp_act  (core_cmp)
  );

  pgt_guard u_guard (
    .clk         (clk),
    .rst         (rst),
    .arm         (arm_q),
    .safe_sel    (safe_q),
    .release_req (release_req),
    .irq_fall    (irq_fall),
    .wave        (wave),
    .pin_out     (tmr_out),
    .pin_oe      (tmr_oe),
    .forced      (forced)
  );

endmodule

// File: rtl/pgt_checker.sv
module pgt_checker
  import pgt_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input pgt_mode_e     mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp_act,
  input logic          forced,
  input logic          tmr_oe,
  input logic          cap_done,
  input logic [CW-1:0] cap_val,
  input logic          ext_fall
);

  // R5: the active compare only changes at a counter clear while running
  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(cmp_act)) |-> (cnt == '0));

  // R3: in toggle/event modes the count never passes the active compare
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (run && (mode == MODE_TOGGLE || mode == MODE_EVENT)) |-> (cnt <= cmp_act));

  // R9: the pin is released only after the guard latched an emergency
  assert_float_forced_R9: assert property (@(posedge clk) disable iff (rst)
    !tmr_oe |-> $past(forced));

  // R8: done flag rises only from a falling input edge in width mode
  assert_cap_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_done) |-> ($past(ext_fall) && $past(mode) == MODE_WIDTH));

  // R8: captured value only moves after a falling input edge
  assert_capval_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_fall) |-> $stable(cap_val));

endmodule

bind pwm_guard_timer pgt_checker #(.CW(CW)) u_pgt_checker (
  .clk      (clk),
  .rst      (rst),
  .run      (run_q),
  .mode     (mode_q),
  .cnt      (core_cnt),
  .cmp_act  (core_cmp),
  .forced   (forced),
  .tmr_oe   (tmr_oe),
  .cap_done (cap_done),
  .cap_val  (cap_val),
  .ext_fall (ext_fall)
);

// File: tb/test_pwm_guard_timer.sv
module test_pwm_guard_timer;

  localparam int CW   = 8;
  localparam int NDIV = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [CW-1:0]   wr_data = '0;
  logic [NDIV-1:0] div_en = '0;
  logic            partner_tick = 1'b0;
  logic            ext_in = 1'b0;
  logic            irq_n = 1'b1;
  logic            tmr_out;
  logic            tmr_oe;
  logic [CW-1:0]   cap_val;
  logic            cap_done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwm_guard_timer i_pwm_guard_timer (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .div_en       (div_en),
    .partner_tick (partner_tick),
    .ext_in       (ext_in),
    .irq_n        (irq_n),
    .tmr_out      (tmr_out),
    .tmr_oe       (tmr_oe),
    .cap_val      (cap_val),
    .cap_done     (cap_done)
  );

  // source code s (1..9) ticks every s+1 cycles; partner every 3 cycles
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < NDIV; i++) div_en[i] = ((cyc % (i + 2)) == 0);
    partner_tick = ((cyc % 3) == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] md, input logic [1:0] sf,
                                     input logic am, input logic rn, input logic rl);
    return {1'b0, rl, rn, am, sf, md};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [1:0] sf, input logic am,
                       input logic [3:0] sel, input logic [7:0] c, input logic [1:0] f);
    wr(2'd0, ctl(md, sf, am, 1'b0, 1'b0));
    wr(2'd1, {4'b0, sel});
    wr(2'd2, c);
    wr(2'd3, {6'b0, f});
    wr(2'd0, ctl(md, sf, am, 1'b1, 1'b0));
  endtask

  task automatic interval(output int n);
    int  k;
    logic p;
    @(negedge clk);
    p = tmr_out; k = 0;
    while (tmr_out == p && k < 5000) begin @(negedge clk); k++; end
    p = tmr_out; n = 0;
    while (tmr_out == p && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic high_count(input int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tmr_out) h++;
    end
  endtask

  task automatic pulse_ext(input int hi, input int lo);
    @(negedge clk); ext_in = 1'b1;
    repeat (hi) @(negedge clk);
    ext_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic irq_edge();
    @(negedge clk); irq_n = 1'b0;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    int n, h, ok;
    int cs[8];
    int pc[6];
    int pf[6];
    int hw[5];
    cs = '{0, 1, 2, 3, 5, 7, 15, 200};
    pc = '{100, 100, 100, 100, 0, 255};
    pf = '{0, 1, 2, 3, 3, 3};
    hw = '{1, 5, 100, 255, 300};

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tmr_out == 1'b0, "R1 tmr_out", tmr_out, 0);
    chk(tmr_oe == 1'b1, "R1 tmr_oe", tmr_oe, 1);
    chk(cap_val == 8'd0, "R1 cap_val", cap_val, 0);
    chk(cap_done == 1'b0, "R1 cap_done", cap_done, 0);

    // R3 toggle interval sweep
    foreach (cs[i]) begin
      setup(2'd0, 2'd0, 1'b0, 4'd0, 8'(cs[i]), 2'd0);
      interval(n);
      chk(n == cs[i] + 1, "R3 toggle interval", n, cs[i] + 1);
      interval(n);
      chk(n == cs[i] + 1, "R3 toggle interval repeat", n, cs[i] + 1);
    end

    // R2 stop drives output low and holds it
    setup(2'd0, 2'd0, 1'b0, 4'd0, 8'd2, 2'd0);
    repeat (10) @(negedge clk);
    wr(2'd0, ctl(2'd0, 2'd0, 1'b0, 1'b0, 1'b0));
    ok = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tmr_out == 1'b0) ok++; end
    chk(ok == 30, "R2 stopped output low", ok, 30);

    // R4 source codes 1..9 from div_en, 11 from partner
    for (int s = 1; s <= 9; s++) begin
      setup(2'd0, 2'd0, 1'b0, 4'(s), 8'd1, 2'd0);
      interval(n);
      chk(n == 2 * (s + 1), "R4 divided source interval", n, 2 * (s + 1));
    end
    setup(2'd0, 2'd0, 1'b0, 4'd11, 8'd1, 2'd0);
    interval(n);
    chk(n == 6, "R4 partner source interval", n, 6);
    setup(2'd0, 2'd0, 1'b0, 4'd13, 8'd0, 2'd0);
    ok = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (tmr_out == 1'b0) ok++; end
    chk(ok == 200, "R4 unused source never ticks", ok, 200);

    // R5 buffered compare
    setup(2'd0, 2'd0, 1'b0, 4'd0, 8'd9, 2'd0);
    interval(n);
    begin
      logic p;
      p = tmr_out; n = 0;
      while (tmr_out == p && n < 5000) begin
        @(negedge clk); n++;
        if (n == 3) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd3; end
        else wr_en = 1'b0;
      end
      wr_en = 1'b0;
      chk(n == 10, "R5 half-period in progress keeps old compare", n, 10);
      p = tmr_out; n = 0;
      while (tmr_out == p && n < 5000) begin @(negedge clk); n++; end
      chk(n == 4, "R5 new compare after clear", n, 4);
    end

    // R6 PWM duty with fractions
    foreach (pc[i]) begin
      setup(2'd1, 2'd0, 1'b0, 4'd0, 8'(pc[i]), 2'(pf[i]));
      repeat (600) @(negedge clk);
      high_count(1024, h);
      chk(h == 4 * pc[i] + pf[i], "R6 PWM high count per group", h, 4 * pc[i] + pf[i]);
    end

    // R7 event counting, compare 2
    setup(2'd2, 2'd0, 1'b0, 4'd0, 8'd2, 2'd0);
    pulse_ext(3, 3); pulse_ext(3, 3);
    repeat (4) @(negedge clk);
    chk(tmr_out == 1'b0, "R7 no toggle after two edges", tmr_out, 0);
    pulse_ext(3, 6);
    chk(tmr_out == 1'b1, "R7 toggle on third edge", tmr_out, 1);
    pulse_ext(3, 3); pulse_ext(3, 3); pulse_ext(3, 6);
    chk(tmr_out == 1'b0, "R7 toggle on sixth edge", tmr_out, 0);

    // R8 width capture, one tick per cycle, saturation
    setup(2'd3, 2'd0, 1'b0, 4'd0, 8'd0, 2'd0);
    foreach (hw[i]) begin
      pulse_ext(hw[i], 8);
      chk(cap_done == 1'b1, "R8 done after fall", cap_done, 1);
      chk(int'(cap_val) == ((hw[i] > 255) ? 255 : hw[i]), "R8 captured width",
          cap_val, (hw[i] > 255) ? 255 : hw[i]);
    end
    @(negedge clk); ext_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(cap_done == 1'b0, "R8 done cleared on rise", cap_done, 0);
    repeat (20) @(negedge clk);
    ext_in = 1'b0;
    repeat (8) @(negedge clk);
    chk(cap_val == 8'd24, "R8 width after clear", cap_val, 24);
    // R4 width with source code 1 (tick every second cycle)
    setup(2'd3, 2'd0, 1'b0, 4'd1, 8'd0, 2'd0);
    pulse_ext(40, 8);
    chk(cap_val == 8'd20, "R4 width counted on divided source", cap_val, 20);

    // R9/R11 forcing to float, latency
    setup(2'd0, 2'd2, 1'b1, 4'd0, 8'd3, 2'd0);
    repeat (10) @(negedge clk);
    irq_edge();
    repeat (3) @(negedge clk);
    chk(tmr_oe == 1'b1, "R11 not forced at third edge", tmr_oe, 1);
    @(negedge clk);
    chk(tmr_oe == 1'b0, "R11 forced at fourth edge", tmr_oe, 0);
    chk(tmr_out == 1'b0, "R9 float state out low", tmr_out, 0);
    irq_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(tmr_oe == 1'b0, "R10 forced state held", tmr_oe, 0);
    wr(2'd0, ctl(2'd0, 2'd2, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    chk(tmr_oe == 1'b1, "R10 release restores enable", tmr_oe, 1);
    interval(n); interval(n);
    chk(n == 4, "R10 toggling resumes", n, 4);

    // R9 forced high
    wr(2'd0, ctl(2'd0, 2'd1, 1'b1, 1'b1, 1'b0));
    irq_edge();
    repeat (5) @(negedge clk);
    irq_n = 1'b1;
    ok = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tmr_out && tmr_oe) ok++; end
    chk(ok == 20, "R9 forced high", ok, 20);
    wr(2'd0, ctl(2'd0, 2'd0, 1'b1, 1'b1, 1'b1));
    repeat (6) @(negedge clk);

    // R9 forced low
    irq_edge();
    repeat (5) @(negedge clk);
    irq_n = 1'b1;
    ok = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!tmr_out && tmr_oe) ok++; end
    chk(ok == 20, "R9 forced low", ok, 20);

    // R9 disarmed edge ignored (release and disarm together)
    wr(2'd0, ctl(2'd0, 2'd2, 1'b0, 1'b1, 1'b1));
    repeat (6) @(negedge clk);
    irq_edge();
    ok = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (tmr_oe) ok++; end
    irq_n = 1'b1;
    chk(ok == 12, "R9 disarmed edge ignored", ok, 12);
    interval(n);
    chk(n == 4, "R9 output still toggling when disarmed", n, 4);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule